// File: doc/BRIEF.md
# Complementary Output Break Control Stage

This block is the pin-side stage of one channel of an advanced PWM timer. It takes the channel's internal reference waveform and produces two pins, a main output and its complement. Each pin comes with its own value and its own output-enable, so a released pin can be tri-stated at the pad. A master output enable gates the pair. A synchronous break input clears the master enable, which sends both pins to a safe state.

While the master enable is low, an off-state select for idle picks between two safe states. In one, both pins are released. In the other, both pins are driven to programmable idle levels. When both idle levels equal the active levels of their pins, both driven values are inverted. This keeps the pair from being parked with both sides active. While the master enable is high, an enabled pin carries the reference through its polarity. A disabled pin of an enabled channel follows the off-state select for run mode.

The channel is set up through a small write-only port with three register slots. A compare-mode field can force the reference to a fixed level regardless of the `ref_i` input. Dead-time insertion and the counter/compare logic live elsewhere.

Top module: `cob_top`

## Requirements
- R1: After a synchronous active-low reset, every register is zero. Both pins are released: enable 0 and value 0.
- R2: With master enable 1, an enabled main pin drives `r XOR pol_m` with enable 1. An enabled complementary pin drives `(NOT r) XOR pol_c` with enable 1. Here `r` is the effective reference.
- R3: With master enable 1 and at least one channel enable set, a pin whose own enable is 0 behaves as follows. If the run off-select is 1, it drives its polarity bit (its inactive level) with enable 1. If the run off-select is 0, it is released.
- R4: With master enable 0 and the idle off-select 0, both pins are released. A released pin always shows value 0.
- R5: With master enable 0, the idle off-select 1 and at least one channel enable set, both pins are driven with enable 1. Each pin drives its own idle bit, unless R6 applies.
- R6: If, in the R5 case, `idle_m == NOT pol_m` and `idle_c == NOT pol_c`, both pin values are inverted relative to their idle bits.
- R7: When both channel enables are 0, both pins are released in every mode. The polarity and idle bits then have no effect.
- R8: A high `brk_i` at a clock edge clears the master enable. This takes priority over a write of 1 to it in the same cycle. The master enable cannot be set again while `brk_i` stays high.
- R9: Compare-mode code 3'b100 forces the effective reference to 0. Code 3'b101 forces it to 1. Any other code passes `ref_i` through.
- R10: Writes occur when `wr_en` is 1 at a clock edge, and `wr_sel` picks the slot.
  - Slot 0 (channel): bit0 en_m, bit1 en_c, bit2 pol_m, bit3 pol_c, bit4 idle_m, bit5 idle_c.
  - Slot 1 (mode): bits[2:0] compare-mode code.
  - Slot 2 (control): bit0 master enable, bit1 idle off-select, bit2 run off-select.
  - Slot 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_i | input | 1 | Break request, active high, sampled at the clock |
| ref_i | input | 1 | Internal reference waveform from the compare logic |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register slot select |
| wr_data | input | 6 | Register write data |
| main_o | output | 1 | Main pin value |
| main_oe_o | output | 1 | Main pin output-enable |
| comp_o | output | 1 | Complementary pin value |
| comp_oe_o | output | 1 | Complementary pin output-enable |

## Verification
The hardest situation to reach from the ports is a break that arrives in the same cycle as a write setting the master enable. A related case is a break held high while software keeps rewriting that enable. The bench drives both together for several cycles and watches the pins fall to the idle state. The conflict inversion needs a particular pairing of idle and polarity bits with the idle off-select chosen. An exhaustive sweep of all ten configuration and reference bits reaches every such pairing. The bench compares both pins and both enables on every clock against a behavioural model.

// File: rtl/cob_pkg.sv
// Package: shared types and encodings for the complementary output stage.
// Assumes one channel with a main and a complementary pin.
package cob_pkg;
    localparam int SEL_W   = 2;
    localparam int DATA_W  = 6;
    localparam int MODE_W  = 3;
    localparam int LANES   = 2;

    localparam logic [SEL_W-1:0]  SEL_CHAN = 2'd0;
    localparam logic [SEL_W-1:0]  SEL_MODE = 2'd1;
    localparam logic [SEL_W-1:0]  SEL_CTRL = 2'd2;

    localparam logic [MODE_W-1:0] MODE_FORCE_LO = 3'b100;
    localparam logic [MODE_W-1:0] MODE_FORCE_HI = 3'b101;

    localparam int CTRL_MOE  = 0;
    localparam int CTRL_IDLE = 1;
    localparam int CTRL_RUN  = 2;

    // Channel slot, bit0 at the bottom: en_m, en_c, pol_m, pol_c, idle_m, idle_c
    typedef struct packed {
        logic idle_c;
        logic idle_m;
        logic pol_c;
        logic pol_m;
        logic en_c;
        logic en_m;
    } chan_cfg_t;
endpackage

// File: rtl/cob_regs.sv
// Module: configuration registers and the master enable with break priority.
// Assumes writes are single-cycle strobes; break is already synchronous to clk.
module cob_regs
    import cob_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_i,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output chan_cfg_t         chan_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              moe_q,
    output logic              off_idle_q,
    output logic              off_run_q
);
    logic wr_chan, wr_mode, wr_ctrl;

    // Decode which slot the current write targets.
    always_comb begin
        wr_chan = wr_en && (wr_sel == SEL_CHAN);
        wr_mode = wr_en && (wr_sel == SEL_MODE);
        wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    end

    // Hold the channel enable, polarity and idle bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_q <= '0;
        else if (wr_chan)
            chan_q <= chan_cfg_t'(wr_data);
    end

    // Hold the compare-mode code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= wr_data[MODE_W-1:0];
    end

    // Hold the off-state selects; break does not touch them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_idle_q <= 1'b0;
            off_run_q  <= 1'b0;
        end else if (wr_ctrl) begin
            off_idle_q <= wr_data[CTRL_IDLE];
            off_run_q  <= wr_data[CTRL_RUN];
        end
    end

    // Master enable: break wins over any software write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            moe_q <= 1'b0;
        else if (brk_i)
            moe_q <= 1'b0;
        else if (wr_ctrl)
            moe_q <= wr_data[CTRL_MOE];
    end
endmodule

// File: rtl/cob_refsel.sv
// Module: picks the effective reference from the compare-mode code.
// Assumes only the two force codes override the incoming reference.
module cob_refsel
    import cob_pkg::*;
(
    input  logic [MODE_W-1:0] mode_q,
    input  logic              ref_i,
    output logic              ref_eff
);
    // Force low, force high, or pass the reference through.
    always_comb begin
        unique case (mode_q)
            MODE_FORCE_LO: ref_eff = 1'b0;
            MODE_FORCE_HI: ref_eff = 1'b1;
            default:       ref_eff = ref_i;
        endcase
    end
endmodule

// File: rtl/cob_conflict.sv
// Module: masks an unused channel and flags an idle pair sitting at active levels.
// Assumes the active level of a pin is the inverse of its polarity bit.
module cob_conflict
    import cob_pkg::*;
(
    input  chan_cfg_t chan_q,
    output chan_cfg_t chan_eff,
    output logic      chan_any,
    output logic      both_active
);
    // Treat polarity and idle bits as zero when the channel is unused.
    always_comb begin
        chan_any = chan_q.en_m | chan_q.en_c;
        chan_eff = chan_any ? chan_q : '0;
    end

    // Raise the flag when both idle bits would put their pins at the active level.
    always_comb begin
        both_active = (chan_eff.idle_m ^ chan_eff.pol_m) &
                      (chan_eff.idle_c ^ chan_eff.pol_c);
    end
endmodule

// File: rtl/cob_pin.sv
// Module: per-pin drive decision for value and output-enable.
// Assumes a released pin reports value 0 alongside enable 0.
module cob_pin (
    input  logic moe,
    input  logic chan_any,
    input  logic own_en,
    input  logic pol,
    input  logic idle,
    input  logic flip,
    input  logic run_val,
    input  logic off_run,
    input  logic off_idle,
    output logic pin_val,
    output logic pin_oe
);
    // Choose between run drive, run off-state, idle drive and release.
    always_comb begin
        pin_val = 1'b0;
        pin_oe  = 1'b0;
        if (chan_any) begin
            if (moe) begin
                if (own_en) begin
                    pin_val = run_val ^ pol;
                    pin_oe  = 1'b1;
                end else if (off_run) begin
                    pin_val = pol;
                    pin_oe  = 1'b1;
                end
            end else if (off_idle) begin
                pin_val = idle ^ flip;
                pin_oe  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cob_top.sv
// Module: complementary output stage with break-driven safe state.
// Assumes brk_i and ref_i are synchronous to clk; pins are combinational
// from registered configuration and the reference.
module cob_top
    import cob_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_i,
    input  logic              ref_i,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              main_o,
    output logic              main_oe_o,
    output logic              comp_o,
    output logic              comp_oe_o
);
    chan_cfg_t         chan_q, chan_eff;
    logic [MODE_W-1:0] mode_q;
    logic              moe_q, off_idle_q, off_run_q;
    logic              ref_eff, chan_any, both_active;
    logic [LANES-1:0]  lane_en, lane_pol, lane_idle, lane_run, lane_val, lane_oe;

    cob_regs u_regs (
        .clk(clk), .rst_n(rst_n), .brk_i(brk_i),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .chan_q(chan_q), .mode_q(mode_q), .moe_q(moe_q),
        .off_idle_q(off_idle_q), .off_run_q(off_run_q)
    );

    cob_refsel u_refsel (.mode_q(mode_q), .ref_i(ref_i), .ref_eff(ref_eff));

    cob_conflict u_conflict (
        .chan_q(chan_q), .chan_eff(chan_eff),
        .chan_any(chan_any), .both_active(both_active)
    );

    // Gather per-lane controls: lane 0 is main, lane 1 is the complement.
    always_comb begin
        lane_en   = {chan_eff.en_c,   chan_eff.en_m};
        lane_pol  = {chan_eff.pol_c,  chan_eff.pol_m};
        lane_idle = {chan_eff.idle_c, chan_eff.idle_m};
        lane_run  = {~ref_eff,        ref_eff};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cob_pin u_pin (
            .moe(moe_q), .chan_any(chan_any), .own_en(lane_en[g]),
            .pol(lane_pol[g]), .idle(lane_idle[g]), .flip(both_active),
            .run_val(lane_run[g]), .off_run(off_run_q), .off_idle(off_idle_q),
            .pin_val(lane_val[g]), .pin_oe(lane_oe[g])
        );
    end

    // Map lanes onto the pin ports.
    always_comb begin
        main_o    = lane_val[0];
        main_oe_o = lane_oe[0];
        comp_o    = lane_val[1];
        comp_oe_o = lane_oe[1];
    end
endmodule

// File: rtl/cob_checker.sv
// Module: assertion checker bound into cob_top.
// Assumes access to the registered configuration of the top module.
module cob_checker
    import cob_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      brk_i,
    input logic      moe_q,
    input logic      off_idle_q,
    input chan_cfg_t chan_q,
    input logic      main_o,
    input logic      main_oe_o,
    input logic      comp_o,
    input logic      comp_oe_o
);
    // R8: a break at an edge leaves the master enable cleared afterwards.
    assert_brk_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> !moe_q);

    // R4: idle off-select 0 with master enable 0 releases both pins.
    assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe_q && !off_idle_q) |-> (!main_oe_o && !comp_oe_o));

    // R4: a released pin shows value 0.
    assert_released_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_oe_o |-> !main_o) and (!comp_oe_o |-> !comp_o));

    // R7: an unused channel never drives.
    assert_unused_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_q.en_m && !chan_q.en_c) |-> (!main_oe_o && !comp_oe_o));

    // R6: in the idle state both pins are never parked at their active levels.
    assert_no_dual_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe_q && main_oe_o && comp_oe_o) |->
        !((main_o != chan_q.pol_m) && (comp_o != chan_q.pol_c)));

    // R5: idle drive asserts both enables together.
    assert_idle_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe_q && off_idle_q && (chan_q.en_m || chan_q.en_c)) |->
        (main_oe_o && comp_oe_o));
endmodule

bind cob_top cob_checker u_chk (
    .clk(clk), .rst_n(rst_n), .brk_i(brk_i), .moe_q(moe_q),
    .off_idle_q(off_idle_q), .chan_q(chan_q),
    .main_o(main_o), .main_oe_o(main_oe_o),
    .comp_o(comp_o), .comp_oe_o(comp_oe_o)
);

// File: tb/test_cob_top.sv
module test_cob_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brk_i = 1'b0;
    logic       ref_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [5:0] wr_data = 6'd0;
    logic       main_o, main_oe_o, comp_o, comp_oe_o;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    // Behavioural model state
    bit m_en, c_en, m_pol, c_pol, m_idle, c_idle, moe, sel_idle, sel_run;
    int mode_code = 0;
    bit prev_brk = 0;

    always #2 clk = ~clk;

    cob_top i_cob_top (
        .clk(clk), .rst_n(rst_n), .brk_i(brk_i), .ref_i(ref_i),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .main_o(main_o), .main_oe_o(main_oe_o),
        .comp_o(comp_o), .comp_oe_o(comp_oe_o)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {main,main_oe,comp,comp_oe} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    // Model register update on every rising edge (R10 slot map, R8 priority).
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_en, c_en, m_pol, c_pol, m_idle, c_idle} <= '0;
            {moe, sel_idle, sel_run} <= '0;
            mode_code <= 0;
            started <= 1;
        end else begin
            if (wr_en && wr_sel == 2'd0) begin
                m_en <= wr_data[0]; c_en <= wr_data[1];
                m_pol <= wr_data[2]; c_pol <= wr_data[3];
                m_idle <= wr_data[4]; c_idle <= wr_data[5];
            end
            if (wr_en && wr_sel == 2'd1) mode_code <= int'(wr_data[2:0]);
            if (wr_en && wr_sel == 2'd2) begin
                sel_idle <= wr_data[1];
                sel_run  <= wr_data[2];
            end
            if (brk_i) moe <= 0;
            else if (wr_en && wr_sel == 2'd2) moe <= wr_data[0];
        end
        prev_brk <= brk_i;
    end

    // Expected pins and the requirement that governs them.
    function automatic logic [3:0] expect_pins(output string tag);
        bit r, mv, mo, cv, co, clash;
        r = (mode_code == 4) ? 1'b0 : (mode_code == 5) ? 1'b1 : ref_i;
        {mv, mo, cv, co} = 4'b0000;
        tag = "R2";
        if (!(m_en || c_en)) begin
            tag = "R7";
        end else if (moe) begin
            if (m_en) begin mv = m_pol ? !r : r; mo = 1; end
            else if (sel_run) begin mv = m_pol; mo = 1; tag = "R3"; end
            else tag = "R3";
            if (c_en) begin cv = c_pol ? r : !r; co = 1; end
            else if (sel_run) begin cv = c_pol; co = 1; tag = "R3"; end
            else tag = "R3";
            if (mode_code == 4 || mode_code == 5) tag = "R9";
        end else if (!sel_idle) begin
            tag = "R4";
        end else begin
            clash = (m_idle == !m_pol) && (c_idle == !c_pol);
            mv = clash ? !m_idle : m_idle;
            cv = clash ? !c_idle : c_idle;
            mo = 1; co = 1;
            tag = clash ? "R6" : "R5";
        end
        if (prev_brk) tag = "R8";
        return {mv, mo, cv, co};
    endfunction

    // Per-clock comparison, sampled after the edge settles.
    always @(posedge clk) begin
        #1;
        if (started && rst_n) begin
            string t;
            logic [3:0] e;
            e = expect_pins(t);
            check(t, {main_o, main_oe_o, comp_o, comp_oe_o}, e);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: released after reset
        check("R1", {main_o, main_oe_o, comp_o, comp_oe_o}, 4'b0000);

        // Exhaustive sweep: R2..R7
        for (int i = 0; i < 1024; i++) begin
            wr(2'd0, {i[5], i[4], i[3], i[2], i[1], i[0]});
            wr(2'd1, 6'd0);
            @(negedge clk); ref_i = i[6];
            wr(2'd2, {3'b000, i[9], i[8], i[7]});
            @(negedge clk);
        end

        // R9: force codes and a non-force code with both ref levels
        wr(2'd0, 6'b000011);
        wr(2'd2, 6'b000001);
        for (int k = 0; k < 8; k++) begin
            wr(2'd1, 6'(k));
            @(negedge clk); ref_i = 1'b0;
            @(negedge clk); ref_i = 1'b1;
            @(negedge clk);
        end
        wr(2'd1, 6'd0);

        // R8: break with a simultaneous master-enable write, held for a while
        wr(2'd2, 6'b000011);
        @(negedge clk);
        brk_i = 1; wr_en = 1; wr_sel = 2'd2; wr_data = 6'b000011;
        repeat (4) @(negedge clk);
        // R8: still idle-driven (both oe) while break is held
        check("R8", {1'b0, main_oe_o, 1'b0, comp_oe_o}, 4'b0101);
        brk_i = 0;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        // R8: enable restored after break drops; run drive {ref^0, ~ref^0}
        check("R8", {main_o, main_oe_o, comp_o, comp_oe_o}, {ref_i, 1'b1, !ref_i, 1'b1});

        // R10: slot 3 writes are ignored
        wr(2'd3, 6'b111111);
        @(negedge clk);
        check("R10", {main_o, main_oe_o, comp_o, comp_oe_o}, {ref_i, 1'b1, !ref_i, 1'b1});

        // R1: reset again mid-run
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1", {main_o, main_oe_o, comp_o, comp_oe_o}, 4'b0000);
        rst_n = 1;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule